// File: doc/BRIEF.md
# JTAG Instruction and Identification Port

This block is the test access port of a configuration memory device. It contains a TMS-driven sixteen-state controller, an eight-bit instruction register and a decoder. Three data registers sit behind it: a one-bit pass-through, a fixed 32-bit identity word and a 32-bit user word. The selected register is placed between `tdi` and `tdo`.

The instruction capture word carries two live status bits, one for the in-system-programming mode and one for the security lock. This lets a host read the device condition during every instruction scan. A dedicated opcode starts configuration of the device downstream by driving a one-period low pulse on `cfg_pulse_n`. A user word that was never programmed reads back as all ones.

This port has no streaming data path. Every pin is a plain control, status or serial pin, so there is no handshake or back-pressure.

Top module: `jtag_id_tap`

## Requirements
- R1: The controller follows the standard sixteen-state graph. It enters Test-Logic-Reset from any state after five rising edges of `tck` with `tms` high, and it stays there while `tms` stays high. `trst_n` low forces Test-Logic-Reset at once, with `tdo_oe` low and `cfg_pulse_n` high.
- R2: While the controller is in Test-Logic-Reset, the active instruction is IDCODE (8'hFE). A data scan that directly follows a reset returns the identity word.
- R3: In Capture-IR the instruction shift stage loads this pattern: bits [7:5]=000, bit 4 = `isp_mode`, bit 3 = `secure_on`, bit 2 = 0 and bits [1:0] = 01. The two status bits are sampled at that edge.
- R4: During Shift-IR the instruction shift stage shifts toward `tdo`, least significant bit first. The active instruction changes only on the rising edge that leaves Update-IR, or in Test-Logic-Reset.
- R5: Decoding: 8'hFE selects the identity register and 8'hFD selects the user register. All other values select the one-bit pass-through register, which captures 0 in Capture-DR. This covers 8'hFF, 8'h01, 8'h00, 8'hFA, 8'hFC, 8'hEE and any opcode not listed.
- R6: The identity word is {version[31:28], family[27:20], product[19:12], manufacturer[11:1], 1}. Each field is a parameter, and the default word is 32'h05026093.
- R7: In Capture-DR the user register loads `user_code` when `user_code_valid` is high, and 32'hFFFFFFFF when it is low.
- R8: The data registers shift toward `tdo` least significant bit first. `tdo` and `tdo_oe` change only on falling edges of `tck`. `tdo_oe` is high exactly while the controller is in Shift-IR or Shift-DR.
- R9: `cfg_pulse_n` goes low for exactly one `tck` period. The pulse starts on the rising edge that leaves Update-IR with 8'hEE in the shift stage. At all other times `cfg_pulse_n` is high, including while 8'hEE sits in the shift stage before Update-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| isp_mode | input | 1 | High while the device is in programming mode |
| secure_on | input | 1 | High when the security lock is set |
| user_code | input | 32 | Programmed user word |
| user_code_valid | input | 1 | High when a user word has been programmed |
| tdo | output | 1 | Serial data out, changes on falling edge |
| tdo_oe | output | 1 | Output enable for `tdo` |
| cfg_pulse_n | output | 1 | Configuration start pulse, active low |

## Verification
A wrong controller state shows up in `tdo_oe` on the next falling edge, because the enable follows only the two shift states. A wrong state also misaligns every captured word, which displaces its bits by whole positions. A decoding fault or a wrong active instruction appears in the first data scan after the instruction update, as the wrong register length or the wrong content. A pulse that fires from the shift stage before Update-IR, or that lasts too long, can be seen on `cfg_pulse_n` in the same or the following period.

// File: rtl/jtag_id_pkg.sv
package jtag_id_pkg;

  localparam int IR_W = 8;

  localparam logic [IR_W-1:0] OP_BYPASS   = 8'hFF;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 8'h01;
  localparam logic [IR_W-1:0] OP_EXTEST   = 8'h00;
  localparam logic [IR_W-1:0] OP_CLAMP    = 8'hFA;
  localparam logic [IR_W-1:0] OP_HIGHZ    = 8'hFC;
  localparam logic [IR_W-1:0] OP_IDCODE   = 8'hFE;
  localparam logic [IR_W-1:0] OP_USERCODE = 8'hFD;
  localparam logic [IR_W-1:0] OP_CONFIG   = 8'hEE;

  typedef enum logic [3:0] {
    ST_RESET  = 4'hF,
    ST_IDLE   = 4'hC,
    ST_SEL_DR = 4'h7,
    ST_CAP_DR = 4'h6,
    ST_SHF_DR = 4'h2,
    ST_EX1_DR = 4'h1,
    ST_PAU_DR = 4'h3,
    ST_EX2_DR = 4'h0,
    ST_UPD_DR = 4'h5,
    ST_SEL_IR = 4'h4,
    ST_CAP_IR = 4'hE,
    ST_SHF_IR = 4'hA,
    ST_EX1_IR = 4'h9,
    ST_PAU_IR = 4'hB,
    ST_EX2_IR = 4'h8,
    ST_UPD_IR = 4'hD
  } tap_state_e;

  typedef enum logic [1:0] {
    PATH_BYP  = 2'd0,
    PATH_ID   = 2'd1,
    PATH_USER = 2'd2
  } dr_path_e;

  function automatic tap_state_e tap_next(input tap_state_e st, input logic m);
    tap_state_e n;
    case (st)
      ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = m ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = m ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
      default:   n = ST_RESET;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_id_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= tap_next(state, tms);
  end

  // R1: held TMS high keeps the controller parked in reset
  assert_tlr_hold_R1: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_RESET && tms) |=> (state == ST_RESET));

  // R1: reset is left only toward Run-Test/Idle
  assert_tlr_exit_R1: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_RESET && !tms) |=> (state == ST_IDLE));

endmodule

// File: rtl/jtag_ir_stage.sv
module jtag_ir_stage
  import jtag_id_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  input  logic            isp_mode,
  input  logic            secure_on,
  output logic            ir_lsb,
  output logic [IR_W-1:0] active_op,
  output logic            cfg_pulse_n
);

  logic [IR_W-1:0] shf_q;
  logic [IR_W-1:0] cap_pat;

  always_comb begin
    cap_pat    = '0;
    cap_pat[0] = 1'b1;
    cap_pat[3] = secure_on;
    cap_pat[4] = isp_mode;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      shf_q <= '0;
    end else if (state == ST_CAP_IR) begin
      shf_q <= cap_pat;
    end else if (state == ST_SHF_IR) begin
      shf_q <= {tdi, shf_q[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      active_op <= OP_IDCODE;
    end else if (state == ST_RESET) begin
      active_op <= OP_IDCODE;
    end else if (state == ST_UPD_IR) begin
      active_op <= shf_q;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) cfg_pulse_n <= 1'b1;
    else         cfg_pulse_n <= !((state == ST_UPD_IR) && (shf_q == OP_CONFIG));
  end

  assign ir_lsb = shf_q[0];

  // R3: capture always leaves the fixed 01 marker in the two low bits
  assert_ir_capture_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_IR) |=> (shf_q[1:0] == 2'b01 && shf_q[2] == 1'b0));

  // R4: active instruction moves only out of Update-IR or in reset
  assert_active_update_R4: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(active_op) |-> ($past(state) == ST_UPD_IR || $past(state) == ST_RESET));

  // R9: pulse only follows Update-IR
  assert_cfg_source_R9: assert property (@(posedge tck) disable iff (!trst_n)
    !cfg_pulse_n |-> ($past(state) == ST_UPD_IR));

  // R9: pulse lasts a single period
  assert_cfg_width_R9: assert property (@(posedge tck) disable iff (!trst_n)
    !cfg_pulse_n |=> cfg_pulse_n);

endmodule

// File: rtl/jtag_ir_decode.sv
module jtag_ir_decode
  import jtag_id_pkg::*;
(
  input  logic [IR_W-1:0] active_op,
  output dr_path_e        path
);

  always_comb begin
    case (active_op)
      OP_IDCODE:   path = PATH_ID;
      OP_USERCODE: path = PATH_USER;
      default:     path = PATH_BYP;
    endcase
  end

endmodule

// File: rtl/jtag_cap_shift.sv
module jtag_cap_shift #(
  parameter int W = 32
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         tdi,
  input  logic         cap_en,
  input  logic         shf_en,
  input  logic [W-1:0] cap_val,
  output logic         so
);

  logic [W-1:0] sr;

  generate
    if (W == 1) begin : g_single
      always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)     sr <= '0;
        else if (cap_en) sr <= cap_val;
        else if (shf_en) sr <= tdi;
      end
    end else begin : g_multi
      always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)     sr <= '0;
        else if (cap_en) sr <= cap_val;
        else if (shf_en) sr <= {tdi, sr[W-1:1]};
      end
    end
  endgenerate

  assign so = sr[0];

  // R5: a capture loads the presented value in full
  assert_capture_load_R5: assert property (@(posedge tck) disable iff (!trst_n)
    cap_en |=> (sr == $past(cap_val)));

endmodule

// File: rtl/jtag_id_tap.sv
module jtag_id_tap
  import jtag_id_pkg::*;
#(
  parameter logic [3:0]  ID_VERSION = 4'h0,
  parameter logic [7:0]  ID_FAMILY  = 8'h50,
  parameter logic [7:0]  ID_PRODUCT = 8'h26,
  parameter logic [10:0] ID_MFR     = 11'h049
) (
  input  logic        tck,
  input  logic        trst_n,
  input  logic        tms,
  input  logic        tdi,
  input  logic        isp_mode,
  input  logic        secure_on,
  input  logic [31:0] user_code,
  input  logic        user_code_valid,
  output logic        tdo,
  output logic        tdo_oe,
  output logic        cfg_pulse_n
);

  localparam int DR_W = 32;
  localparam logic [DR_W-1:0] ID_WORD = {ID_VERSION, ID_FAMILY, ID_PRODUCT, ID_MFR, 1'b1};

  tap_state_e      state;
  logic            ir_lsb;
  logic [IR_W-1:0] active_op;
  dr_path_e        path;
  logic            cap_dr, shf_dr;
  logic            byp_so, id_so, usr_so, dr_so;
  logic [DR_W-1:0] usr_val;
  logic            tdo_q, oe_q;

  jtag_tap_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (state)
  );

  jtag_ir_stage u_ir (
    .tck         (tck),
    .trst_n      (trst_n),
    .tdi         (tdi),
    .state       (state),
    .isp_mode    (isp_mode),
    .secure_on   (secure_on),
    .ir_lsb      (ir_lsb),
    .active_op   (active_op),
    .cfg_pulse_n (cfg_pulse_n)
  );

  jtag_ir_decode u_dec (
    .active_op (active_op),
    .path      (path)
  );

  assign cap_dr  = (state == ST_CAP_DR);
  assign shf_dr  = (state == ST_SHF_DR);
  assign usr_val = user_code_valid ? user_code : '1;

  jtag_cap_shift #(.W(1)) u_byp (
    .tck     (tck),
    .trst_n  (trst_n),
    .tdi     (tdi),
    .cap_en  (cap_dr && path == PATH_BYP),
    .shf_en  (shf_dr && path == PATH_BYP),
    .cap_val (1'b0),
    .so      (byp_so)
  );

  jtag_cap_shift #(.W(DR_W)) u_id (
    .tck     (tck),
    .trst_n  (trst_n),
    .tdi     (tdi),
    .cap_en  (cap_dr && path == PATH_ID),
    .shf_en  (shf_dr && path == PATH_ID),
    .cap_val (ID_WORD),
    .so      (id_so)
  );

  jtag_cap_shift #(.W(DR_W)) u_usr (
    .tck     (tck),
    .trst_n  (trst_n),
    .tdi     (tdi),
    .cap_en  (cap_dr && path == PATH_USER),
    .shf_en  (shf_dr && path == PATH_USER),
    .cap_val (usr_val),
    .so      (usr_so)
  );

  always_comb begin
    case (path)
      PATH_ID:   dr_so = id_so;
      PATH_USER: dr_so = usr_so;
      default:   dr_so = byp_so;
    endcase
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q  <= (state == ST_SHF_IR) || (state == ST_SHF_DR);
      tdo_q <= (state == ST_SHF_IR) ? ir_lsb : dr_so;
    end
  end

  assign tdo    = tdo_q;
  assign tdo_oe = oe_q;

  // R8: enable seen at a rising edge belongs to a shift state
  assert_oe_shift_R8: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == ST_SHF_IR || state == ST_SHF_DR));

  // R6: identity word always starts with a one
  assert_id_lsb_R6: assert property (@(posedge tck) disable iff (!trst_n)
    (cap_dr && path == PATH_ID) |=> id_so);

  // R7: unprogrammed user word reads ones
  assert_user_blank_R7: assert property (@(posedge tck) disable iff (!trst_n)
    (cap_dr && path == PATH_USER && !user_code_valid) |=> usr_so);

  // R5: pass-through captures zero
  assert_bypass_zero_R5: assert property (@(posedge tck) disable iff (!trst_n)
    (cap_dr && path == PATH_BYP) |=> !byp_so);

endmodule

// File: tb/tb_jtag_id_tap.sv
module tb_jtag_id_tap;

  localparam int TCK_PERIOD = 20;
  localparam logic [31:0] EXP_ID = 32'h05026093;

  typedef struct packed {
    logic [7:0]  op;
    logic        isp;
    logic        sec;
    logic        uvalid;
    logic [31:0] ucode;
    logic [31:0] din;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{8'hFE, 1'b0, 1'b0, 1'b1, 32'h12345678, 32'h00000000},
    '{8'hFD, 1'b1, 1'b0, 1'b1, 32'hA5C30F96, 32'h00000000},
    '{8'hFD, 1'b0, 1'b1, 1'b0, 32'hA5C30F96, 32'h00000000},
    '{8'hFF, 1'b1, 1'b1, 1'b1, 32'h00000000, 32'h9E3779B9},
    '{8'h01, 1'b0, 1'b0, 1'b1, 32'h00000000, 32'h0F0F1234},
    '{8'h00, 1'b1, 1'b0, 1'b0, 32'h00000000, 32'hDEADBEEF},
    '{8'hFA, 1'b0, 1'b1, 1'b1, 32'h00000000, 32'h80000001},
    '{8'hFC, 1'b1, 1'b1, 1'b0, 32'h00000000, 32'h7FFFFFFE},
    '{8'hEE, 1'b0, 1'b0, 1'b1, 32'h00000000, 32'h13579BDF},
    '{8'h55, 1'b1, 1'b0, 1'b1, 32'h00000000, 32'hCAFEF00D},
    '{8'hFE, 1'b1, 1'b1, 1'b0, 32'hFFFF0000, 32'h00000000}
  };

  logic        tck = 1'b0;
  logic        trst_n = 1'b0;
  logic        tms = 1'b1;
  logic        tdi = 1'b0;
  logic        isp_mode = 1'b0;
  logic        secure_on = 1'b0;
  logic [31:0] user_code = '0;
  logic        user_code_valid = 1'b0;
  logic        tdo, tdo_oe, cfg_pulse_n;

  int checks = 0;
  int fails = 0;
  logic done = 1'b0;
  logic s_tdo, s_oe, s_cfg;

  always #(TCK_PERIOD/2) tck = ~tck;

  jtag_id_tap dut (
    .tck             (tck),
    .trst_n          (trst_n),
    .tms             (tms),
    .tdi             (tdi),
    .isp_mode        (isp_mode),
    .secure_on       (secure_on),
    .user_code       (user_code),
    .user_code_valid (user_code_valid),
    .tdo             (tdo),
    .tdo_oe          (tdo_oe),
    .cfg_pulse_n     (cfg_pulse_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one TCK period: drive after the falling edge, sample the state that precedes the next rise
  task automatic tick(input logic m, input logic d);
    @(negedge tck);
    #1;
    tms = m;
    tdi = d;
    s_tdo = tdo;
    s_oe = tdo_oe;
    s_cfg = cfg_pulse_n;
  endtask

  task automatic scan_ir(input logic [7:0] op, output logic [7:0] cap, output logic oe_all);
    oe_all = 1'b1;
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      tick(i == 7, op[i]);
      cap[i] = s_tdo;
      oe_all &= s_oe;
    end
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  task automatic scan_dr(input logic [31:0] din, output logic [31:0] dout, output logic oe_all);
    oe_all = 1'b1;
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    for (int i = 0; i < 32; i++) begin
      tick(i == 31, din[i]);
      dout[i] = s_tdo;
      oe_all &= s_oe;
    end
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  function automatic logic [31:0] exp_dr(input vec_t v);
    if (v.op == 8'hFE) return EXP_ID;
    if (v.op == 8'hFD) return v.uvalid ? v.ucode : 32'hFFFFFFFF;
    return {v.din[30:0], 1'b0};
  endfunction

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(TCK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0]  icap;
    logic [31:0] dout;
    logic        oe_all;

    // reset state (R1, R8, R9)
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    chk("R1 tdo_oe in reset", {31'd0, s_oe}, 32'd0);
    chk("R9 cfg_pulse_n in reset", {31'd0, s_cfg}, 32'd1);
    trst_n = 1'b1;
    tick(1'b0, 1'b0);
    chk("R8 tdo_oe idle", {31'd0, s_oe}, 32'd0);
    scan_dr(32'h0, dout, oe_all);
    chk("R2 identity after reset", dout, EXP_ID);
    chk("R8 oe during shift-dr", {31'd0, oe_all}, 32'd1);

    // vector table
    for (int k = 0; k < NV; k++) begin
      isp_mode = VECS[k].isp;
      secure_on = VECS[k].sec;
      user_code = VECS[k].ucode;
      user_code_valid = VECS[k].uvalid;
      scan_ir(VECS[k].op, icap, oe_all);
      chk("R3 capture pattern", {24'd0, icap},
          {24'd0, 3'b000, VECS[k].isp, VECS[k].sec, 3'b001});
      chk("R8 oe during shift-ir", {31'd0, oe_all}, 32'd1);
      tick(1'b0, 1'b0);
      chk("R9 pulse after update", {31'd0, s_cfg}, {31'd0, VECS[k].op != 8'hEE});
      scan_dr(VECS[k].din, dout, oe_all);
      if (VECS[k].op == 8'hFD) chk("R7 user word", dout, exp_dr(VECS[k]));
      else if (VECS[k].op == 8'hFE) chk("R6 identity word", dout, exp_dr(VECS[k]));
      else chk("R5 bypass path", dout, exp_dr(VECS[k]));
    end

    // R1: five TMS-high periods from Shift-DR reach reset, R2 restores IDCODE
    scan_ir(8'hFF, icap, oe_all);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    chk("R1 oe low after tms reset", {31'd0, s_oe}, 32'd0);
    scan_dr(32'h0, dout, oe_all);
    chk("R1 R2 identity after tms reset", dout, EXP_ID);

    // R4, R9: CONFIG parked in the shift stage must not fire before Update-IR
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) tick(i == 7, 8'hEE >> i);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    chk("R9 no pulse before update", {31'd0, s_cfg}, 32'd1);
    chk("R8 oe low in pause-ir", {31'd0, s_oe}, 32'd0);
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    chk("R9 pulse low after update", {31'd0, s_cfg}, 32'd0);
    tick(1'b0, 1'b0);
    chk("R9 pulse one period", {31'd0, s_cfg}, 32'd1);
    scan_dr(32'h0000_0003, dout, oe_all);
    chk("R4 R5 active now bypass", dout, 32'h0000_0006);

    // R1: asynchronous reset during Shift-DR
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    chk("R8 oe high in shift-dr", {31'd0, s_oe}, 32'd1);
    trst_n = 1'b0;
    #2;
    chk("R1 async reset drops oe", {31'd0, tdo_oe}, 32'd0);
    tick(1'b1, 1'b0);
    trst_n = 1'b1;
    tick(1'b0, 1'b0);
    scan_dr(32'h0, dout, oe_all);
    chk("R2 identity after async reset", dout, EXP_ID);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule